// File: doc/BRIEF.md
# Program Counter Branch Target Unit

This block works out the next 16-bit program counter for a small 8-bit microcontroller core. On each enabled step it takes the current program counter, the length of the instruction being retired, a two-bit branch kind, a taken flag, the opcode byte and up to two operand bytes. It registers the resulting next program counter. The kinds are plain sequential advance, a signed short relative jump, a jump that replaces only the low 11 bits (page-absolute), and a long jump to a full 16-bit destination.

Next to the next program counter, the block registers the address of the following instruction. A call sequence pushes this value as its return address. Instruction decode, evaluation of branch conditions and stack writes are handled elsewhere. A condition arrives here only as the taken flag. All address arithmetic wraps modulo 2^16.

Top module: `pc_branch_unit`

## Requirements
- R1: While `rst_n` is low, and after its release until the first enabled step, `next_pc` and `link_addr` are both 0x0000.
- R2: With `br_kind` = 0 (sequential), an enabled step loads `next_pc` with `cur_pc + instr_len`, where `instr_len` is an unsigned byte count from 1 to 3.
- R3: Every enabled step loads `link_addr` with `cur_pc + instr_len`, whatever the branch kind.
- R4: With `br_kind` = 1 (relative) and `taken` = 1, `next_pc` becomes `cur_pc + instr_len` plus the offset, taken as a two's-complement 8-bit value. The offset byte is `op_b2` when `instr_len` = 3 and `op_b1` otherwise.
- R5: With `br_kind` = 1 and `taken` = 0, `next_pc` becomes `cur_pc + instr_len`.
- R6: With `br_kind` = 2 (page-absolute), `next_pc` = {(`cur_pc + instr_len`)[15:11], `opcode`[7:5], `op_b1`[7:0]}. The upper five bits therefore come from the advanced address, even when the instruction crosses a 2 KB boundary.
- R7: With `br_kind` = 3 (long), `next_pc` = {`op_b1`, `op_b2`}, with `op_b1` as the high byte.
- R8: `taken` has no effect on the result for branch kinds 0, 2 and 3.
- R9: All additions wrap modulo 2^16, both forward past 0xFFFF and backward below 0x0000.
- R10: While `step_en` is low, `next_pc` and `link_addr` keep their values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Clock enable for one program-counter update |
| cur_pc | input | 16 | Address of the current instruction |
| instr_len | input | 2 | Length of the current instruction in bytes |
| br_kind | input | 2 | 0 sequential, 1 relative, 2 page-absolute, 3 long |
| taken | input | 1 | Condition result for relative branches |
| opcode | input | 8 | Opcode byte of the current instruction |
| op_b1 | input | 8 | First operand byte |
| op_b2 | input | 8 | Second operand byte |
| next_pc | output | 16 | Registered next program counter |
| link_addr | output | 16 | Registered address of the following instruction |

## Verification
The vector table drives each branch kind with instruction lengths 1, 2 and 3. Relative offsets are positive, negative and at the -128 extreme, and that case tells apart which operand byte supplies the offset. Page-absolute targets are tried once inside a 2 KB page and once where the advanced address crosses into the next page, which separates pre-advance from post-advance page bits. Inputs that wrap past 0xFFFF and below zero, vectors that flip `taken` on the non-relative kinds, and a hold with `step_en` low while the inputs are scrambled cover the remaining requirements.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  typedef enum logic [1:0] {
    BR_SEQ  = 2'd0,
    BR_REL  = 2'd1,
    BR_PAGE = 2'd2,
    BR_LONG = 2'd3
  } br_kind_e;

endpackage

// File: rtl/pcu_seq_adder.sv
module pcu_seq_adder #(
  parameter int PC_W  = 16,
  parameter int LEN_W = 2
) (
  input  logic [PC_W-1:0]  base_pc,
  input  logic [LEN_W-1:0] len,
  output logic [PC_W-1:0]  adv_pc
);
  localparam int PAD_W = PC_W - LEN_W;

  // modulo 2^PC_W by truncation of the sum
  always_comb begin
    adv_pc = base_pc + {{PAD_W{1'b0}}, len};
  end

endmodule

// File: rtl/pcu_rel_target.sv
module pcu_rel_target #(
  parameter int PC_W    = 16,
  parameter int BYTE_W  = 8,
  parameter int LEN_W   = 2,
  parameter int FAR_LEN = 3
) (
  input  logic [PC_W-1:0]   adv_pc,
  input  logic [LEN_W-1:0]  len,
  input  logic [BYTE_W-1:0] op_b1,
  input  logic [BYTE_W-1:0] op_b2,
  output logic [PC_W-1:0]   rel_pc
);
  localparam int EXT_W = PC_W - BYTE_W;

  logic [BYTE_W-1:0] disp;
  logic [PC_W-1:0]   disp_ext;

  // the displacement is always the last operand byte of the instruction
  always_comb begin
    disp     = (len == LEN_W'(FAR_LEN)) ? op_b2 : op_b1;
    disp_ext = {{EXT_W{disp[BYTE_W-1]}}, disp};
    rel_pc   = adv_pc + disp_ext;
  end

endmodule

// File: rtl/pcu_page_target.sv
module pcu_page_target #(
  parameter int PC_W   = 16,
  parameter int BYTE_W = 8,
  parameter int PAGE_W = 11
) (
  input  logic [PC_W-1:0]   adv_pc,
  input  logic [BYTE_W-1:0] opcode,
  input  logic [BYTE_W-1:0] op_b1,
  output logic [PC_W-1:0]   page_pc
);
  localparam int OPC_BITS = PAGE_W - BYTE_W;

  logic [PAGE_W-1:0] in_page;

  always_comb begin
    in_page = {opcode[BYTE_W-1 -: OPC_BITS], op_b1};
    page_pc = {adv_pc[PC_W-1:PAGE_W], in_page};
  end

endmodule

// File: rtl/pc_branch_unit.sv
module pc_branch_unit
  import pcu_pkg::*;
#(
  parameter int PC_W    = 16,
  parameter int BYTE_W  = 8,
  parameter int LEN_W   = 2,
  parameter int PAGE_W  = 11,
  parameter int FAR_LEN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic [PC_W-1:0]   cur_pc,
  input  logic [LEN_W-1:0]  instr_len,
  input  logic [1:0]        br_kind,
  input  logic              taken,
  input  logic [BYTE_W-1:0] opcode,
  input  logic [BYTE_W-1:0] op_b1,
  input  logic [BYTE_W-1:0] op_b2,
  output logic [PC_W-1:0]   next_pc,
  output logic [PC_W-1:0]   link_addr
);
  localparam int DEST_W = 2 * BYTE_W;

  br_kind_e          kind;
  logic [PC_W-1:0]   adv_pc;
  logic [PC_W-1:0]   rel_pc;
  logic [PC_W-1:0]   page_pc;
  logic [PC_W-1:0]   long_pc;
  logic [DEST_W-1:0] long_raw;
  logic [PC_W-1:0]   pc_d;
  logic [PC_W-1:0]   link_d;

  assign kind     = br_kind_e'(br_kind);
  assign long_raw = {op_b1, op_b2};

  pcu_seq_adder #(
    .PC_W  (PC_W),
    .LEN_W (LEN_W)
  ) u_seq (
    .base_pc (cur_pc),
    .len     (instr_len),
    .adv_pc  (adv_pc)
  );

  pcu_rel_target #(
    .PC_W    (PC_W),
    .BYTE_W  (BYTE_W),
    .LEN_W   (LEN_W),
    .FAR_LEN (FAR_LEN)
  ) u_rel (
    .adv_pc (adv_pc),
    .len    (instr_len),
    .op_b1  (op_b1),
    .op_b2  (op_b2),
    .rel_pc (rel_pc)
  );

  pcu_page_target #(
    .PC_W   (PC_W),
    .BYTE_W (BYTE_W),
    .PAGE_W (PAGE_W)
  ) u_page (
    .adv_pc  (adv_pc),
    .opcode  (opcode),
    .op_b1   (op_b1),
    .page_pc (page_pc)
  );

  // long destination fitted to the program counter width
  generate
    if (PC_W == DEST_W) begin : g_long_exact
      assign long_pc = long_raw;
    end else if (PC_W > DEST_W) begin : g_long_pad
      assign long_pc = {{(PC_W-DEST_W){1'b0}}, long_raw};
    end else begin : g_long_trim
      assign long_pc = long_raw[PC_W-1:0];
    end
  endgenerate

  // next-state selection
  always_comb begin
    link_d = adv_pc;
    unique case (kind)
      BR_SEQ:  pc_d = adv_pc;
      BR_REL:  pc_d = taken ? rel_pc : adv_pc;
      BR_PAGE: pc_d = page_pc;
      BR_LONG: pc_d = long_pc;
      default: pc_d = adv_pc;
    endcase
  end

  // state registers with explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_pc   <= '0;
      link_addr <= '0;
    end else if (step_en) begin
      next_pc   <= pc_d;
      link_addr <= link_d;
    end
  end

  // R10: outputs frozen while the enable is low
  a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> ($stable(next_pc) && $stable(link_addr)));

  // R3: return address is the instruction following the current one
  a_r3_link_follows: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |=> (link_addr == PC_W'($past(cur_pc) + PC_W'($past(instr_len)))));

  // R2: sequential step lands on the return address
  a_r2_seq_matches_link: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && kind == BR_SEQ) |=> (next_pc == link_addr));

  // R5: a relative branch that is not taken falls through
  a_r5_untaken_falls_through: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && kind == BR_REL && !taken) |=> (next_pc == link_addr));

  // R6: page jump keeps the upper bits of the advanced address
  a_r6_page_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && kind == BR_PAGE) |=> (next_pc[PC_W-1:PAGE_W] == link_addr[PC_W-1:PAGE_W]));

endmodule

// File: tb/pc_branch_unit_tb.sv
`timescale 1ns/1ps
module pc_branch_unit_tb;

  typedef struct packed {
    logic [15:0] cur;
    logic [1:0]  len;
    logic [1:0]  kind;
    logic        tk;
    logic [7:0]  opc;
    logic [7:0]  b1;
    logic [7:0]  b2;
    logic [15:0] exp_pc;
    logic [15:0] exp_link;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{16'h1234, 2'd1, 2'd0, 1'b0, 8'h00, 8'h00, 8'h00, 16'h1235, 16'h1235, 4'd2}, // R2
    '{16'h1234, 2'd3, 2'd0, 1'b1, 8'h00, 8'hAA, 8'h55, 16'h1237, 16'h1237, 4'd8}, // R8 taken on sequential
    '{16'h0100, 2'd2, 2'd1, 1'b1, 8'h80, 8'h10, 8'h00, 16'h0112, 16'h0102, 4'd4}, // R4 forward
    '{16'h0100, 2'd2, 2'd1, 1'b1, 8'h80, 8'hFE, 8'h00, 16'h0100, 16'h0102, 4'd4}, // R4 backward
    '{16'h2000, 2'd3, 2'd1, 1'b1, 8'hB4, 8'h55, 8'h80, 16'h1F83, 16'h2003, 4'd4}, // R4 offset from op_b2
    '{16'h2000, 2'd3, 2'd1, 1'b0, 8'hB4, 8'h55, 8'h80, 16'h2003, 16'h2003, 4'd5}, // R5
    '{16'h4800, 2'd2, 2'd2, 1'b1, 8'hE1, 8'h23, 8'h00, 16'h4F23, 16'h4802, 4'd6}, // R6 in page
    '{16'h07FF, 2'd2, 2'd2, 1'b1, 8'h01, 8'h40, 8'h00, 16'h0840, 16'h0801, 4'd6}, // R6 page crossing
    '{16'h4800, 2'd2, 2'd2, 1'b0, 8'hA1, 8'h00, 8'h00, 16'h4D00, 16'h4802, 4'd8}, // R8 on page kind
    '{16'h0010, 2'd3, 2'd3, 1'b1, 8'h02, 8'hBE, 8'hEF, 16'hBEEF, 16'h0013, 4'd7}, // R7
    '{16'h1000, 2'd3, 2'd3, 1'b0, 8'h02, 8'h00, 8'h00, 16'h0000, 16'h1003, 4'd8}, // R8 on long kind
    '{16'hFFFF, 2'd2, 2'd0, 1'b0, 8'h00, 8'h00, 8'h00, 16'h0001, 16'h0001, 4'd9}, // R9 forward wrap
    '{16'hFFFE, 2'd2, 2'd1, 1'b1, 8'h80, 8'h7F, 8'h00, 16'h007F, 16'h0000, 4'd9}, // R9 relative wrap
    '{16'h0000, 2'd2, 2'd1, 1'b1, 8'h80, 8'h80, 8'h00, 16'hFF82, 16'h0002, 4'd9}  // R9 backward wrap
  };

  logic        clk;
  logic        rst_n;
  logic        step_en;
  logic [15:0] cur_pc;
  logic [1:0]  instr_len;
  logic [1:0]  br_kind;
  logic        taken;
  logic [7:0]  opcode;
  logic [7:0]  op_b1;
  logic [7:0]  op_b2;
  logic [15:0] next_pc;
  logic [15:0] link_addr;

  int checks;
  int errors;
  bit done;

  pc_branch_unit u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en   (step_en),
    .cur_pc    (cur_pc),
    .instr_len (instr_len),
    .br_kind   (br_kind),
    .taken     (taken),
    .opcode    (opcode),
    .op_b1     (op_b1),
    .op_b2     (op_b2),
    .next_pc   (next_pc),
    .link_addr (link_addr)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check16(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v, input logic en);
    step_en   = en;
    cur_pc    = v.cur;
    instr_len = v.len;
    br_kind   = v.kind;
    taken     = v.tk;
    opcode    = v.opc;
    op_b1     = v.b1;
    op_b2     = v.b2;
  endtask

  initial begin
    checks  = 0;
    errors  = 0;
    done    = 1'b0;
    rst_n   = 1'b0;
    drive(VECS[0], 1'b0);
    repeat (3) @(negedge clk);
    // R1: reset state
    check16("R1", "next_pc in reset", next_pc, 16'h0000);
    check16("R1", "link_addr in reset", link_addr, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    check16("R1", "next_pc after release", next_pc, 16'h0000);

    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i], 1'b1);
      @(posedge clk);
      @(negedge clk);
      check16($sformatf("R%0d", VECS[i].req), $sformatf("vec %0d next_pc", i),
              next_pc, VECS[i].exp_pc);
      check16("R3", $sformatf("vec %0d link_addr", i), link_addr, VECS[i].exp_link);
    end

    // R10: enable low, scrambled inputs, outputs must hold (last: FF82 / 0002)
    drive('{16'h5A5A, 2'd3, 2'd3, 1'b1, 8'hFF, 8'h12, 8'h34, 16'h0, 16'h0, 4'd10}, 1'b0);
    repeat (3) @(negedge clk);
    check16("R10", "next_pc held", next_pc, 16'hFF82);
    check16("R10", "link_addr held", link_addr, 16'h0002);

    // R4: length 2 must take the offset from op_b1 even if op_b2 differs
    drive('{16'h0300, 2'd2, 2'd1, 1'b1, 8'h80, 8'h04, 8'hF0, 16'h0, 16'h0, 4'd4}, 1'b1);
    @(posedge clk);
    @(negedge clk);
    check16("R4", "len2 uses op_b1", next_pc, 16'h0306);

    // R1: reset again mid-run
    step_en = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check16("R1", "next_pc mid-run reset", next_pc, 16'h0000);
    check16("R1", "link_addr mid-run reset", link_addr, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule